// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds a set of identical register copies that all answer at one bus address, the shared window. A selector register picks one copy through a group field and an instance field, and a broadcast bit decides whether a write to the shared window lands in every copy or only in the steered one. Reads of the shared window always return exactly one copy, the steered one. The broadcast bit has no effect on reads.

Each copy can be marked absent by a fuse-off mask or by a power-gate mask, both plain inputs. A read steered to an absent copy returns zero. A unicast write steered to an absent copy is dropped and leaves the copy unchanged. A broadcast write updates every copy, present or absent, so an ungated copy later shows the broadcast value. A one-bit ownership semaphore at its own address lets several software agents take turns at reprogramming the selector.

The semaphore is a two-state machine. In SEM_FREE, a read of the semaphore returns 1, and the transition take moves it to SEM_HELD. In SEM_HELD, reads return 0 and the state does not change. A write with bit 0 set is the transition release, back to SEM_FREE. A write with bit 0 set has priority over a read in the same cycle. The bus is synchronous: a write takes effect at the clock edge where it is presented, and read data appears one clock after the read strobe.

Top module: `steered_reg_bank`

## Requirements
- R1: After reset the selector reads 0x10 (broadcast bit set, group 0, instance 0), every copy holds zero, the semaphore is in SEM_FREE, and the read data output is zero.
- R2: Word address 0 is the selector. Bits [1:0] are the instance, bits [3:2] are the group and bit 4 is the broadcast bit. A write stores bits [4:0], and a read returns them with all upper bits zero.
- R3: A write to the shared window (word address 1) while the broadcast bit is 1 sets all 16 copies to the written value.
- R4: A write to the shared window while the broadcast bit is 0 updates only copy group*4+instance, and it only does so when that copy is present. All other copies keep their values.
- R5: A read strobe at word address 1 returns, on the next clock, copy group*4+instance, whatever the broadcast bit is. In a cycle after a clock with no read strobe, read data is zero.
- R6: A shared-window read steered to a copy whose fuse-off bit or power-gate bit is 1 returns zero.
- R7: A unicast write steered to a copy whose fuse-off bit or power-gate bit is 1 is discarded. After the mask bit is cleared, the copy still reads its earlier value.
- R8: A read of the semaphore (word address 2) in SEM_FREE returns 1 and moves it to SEM_HELD. Every read in SEM_HELD returns 0.
- R9: A write to the semaphore with bit 0 equal to 1 returns it to SEM_FREE. A write with bit 0 equal to 0 has no effect.
- R10: A read of word address 3 returns zero. A write to it changes neither the selector nor any copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Word address: 0 selector, 1 shared window, 2 semaphore |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the clock after bus_rd |
| fuse_off | input | 16 | Per-copy fuse-off mask, bit index group*4+instance |
| pwr_gate | input | 16 | Per-copy power-gate mask, bit index group*4+instance |

## Verification
A wrong selector or copy-index decode shows up at the next shared-window read. The wrong copy's value, or a stale one, appears on bus_rdata one clock after the strobe. A mask or broadcast error can stay hidden in storage until a later read of that particular copy, so the stimulus reads every copy after each broadcast and reads again after mask bits are cleared. A semaphore state error shows up on the very next semaphore read as a 1 where a 0 is due, or the other way round.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int BUS_AW = 2;

    localparam logic [BUS_AW-1:0] ADR_SEL    = 2'd0;
    localparam logic [BUS_AW-1:0] ADR_SHARED = 2'd1;
    localparam logic [BUS_AW-1:0] ADR_SEM    = 2'd2;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_t;
endpackage

// File: rtl/srb_selector.sv
module srb_selector #(
    parameter int GRP_W  = 2,
    parameter int INST_W = 2,
    localparam int SEL_W = GRP_W + INST_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [SEL_W-1:0]  wr_val,
    output logic [GRP_W-1:0]  grp,
    output logic [INST_W-1:0] inst,
    output logic              bcast,
    output logic [SEL_W-1:0]  word
);
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= {1'b1, {(SEL_W-1){1'b0}}};
        else if (wr_hit)
            sel_q <= wr_val;
    end

    assign inst  = sel_q[INST_W-1:0];
    assign grp   = sel_q[INST_W +: GRP_W];
    assign bcast = sel_q[SEL_W-1];
    assign word  = sel_q;

    a_r2_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> word == $past(wr_val));
endmodule

// File: rtl/srb_semaphore.sv
module srb_semaphore
    import srb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_hit,
    input  logic rel_hit,
    output logic grant,
    output logic held
);
    sem_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEM_FREE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: if (rel_hit)      state_d = SEM_FREE;
                      else if (rd_hit)  state_d = SEM_HELD;
            SEM_HELD: if (rel_hit)      state_d = SEM_FREE;
            default:                    state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        grant = 1'b0;
        held  = 1'b0;
        unique case (state_q)
            SEM_FREE: grant = rd_hit;
            SEM_HELD: held  = 1'b1;
            default: ;
        endcase
    end

    a_r8_take: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !held && !rel_hit) |=> held);
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        rel_hit |=> !held);
endmodule

// File: rtl/srb_copy_bank.sv
module srb_copy_bank #(
    parameter int NUM_COPIES = 16,
    parameter int DATA_W     = 32,
    localparam int IDX_W     = $clog2(NUM_COPIES)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_all,
    input  logic                                wr_one,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [NUM_COPIES-1:0][DATA_W-1:0]   copies
);
    for (genvar i = 0; i < NUM_COPIES; i++) begin : g_copy
        logic hit;
        assign hit = wr_all || (wr_one && (wr_idx == IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n)
                copies[i] <= '0;
            else if (hit)
                copies[i] <= wdata;
        end

        a_r3_bcast_fill: assert property (@(posedge clk) disable iff (!rst_n)
            wr_all |=> copies[i] == $past(wdata));
        a_r4_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_all && wr_idx != IDX_W'(i)) |=> $stable(copies[i]));
    end
endmodule

// File: rtl/steered_reg_bank.sv
module steered_reg_bank
    import srb_pkg::*;
#(
    parameter int NUM_GRP  = 4,
    parameter int NUM_INST = 4,
    parameter int DATA_W   = 32,
    localparam int GRP_W   = $clog2(NUM_GRP),
    localparam int INST_W  = $clog2(NUM_INST),
    localparam int SEL_W   = GRP_W + INST_W + 1,
    localparam int NCOPY   = NUM_GRP * NUM_INST,
    localparam int IDX_W   = $clog2(NCOPY)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NCOPY-1:0]  fuse_off,
    input  logic [NCOPY-1:0]  pwr_gate
);
    logic [GRP_W-1:0]              sel_grp;
    logic [INST_W-1:0]             sel_inst;
    logic                          sel_bcast;
    logic [SEL_W-1:0]              sel_word;
    logic [IDX_W-1:0]              steer_idx;
    logic                          steer_live;
    logic [NCOPY-1:0][DATA_W-1:0]  copies;
    logic                          sem_grant, sem_held;
    logic                          wr_sel, wr_shared, rel_sem, rd_sem;

    assign wr_sel    = bus_wr && bus_addr == ADR_SEL;
    assign wr_shared = bus_wr && bus_addr == ADR_SHARED;
    assign rel_sem   = bus_wr && bus_addr == ADR_SEM && bus_wdata[0];
    assign rd_sem    = bus_rd && bus_addr == ADR_SEM;

    srb_selector #(.GRP_W(GRP_W), .INST_W(INST_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hit(wr_sel),
        .wr_val(bus_wdata[SEL_W-1:0]),
        .grp   (sel_grp),
        .inst  (sel_inst),
        .bcast (sel_bcast),
        .word  (sel_word)
    );

    assign steer_idx  = IDX_W'(sel_grp) * IDX_W'(NUM_INST) + IDX_W'(sel_inst);
    assign steer_live = !fuse_off[steer_idx] && !pwr_gate[steer_idx];

    srb_copy_bank #(.NUM_COPIES(NCOPY), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_all(wr_shared && sel_bcast),
        .wr_one(wr_shared && !sel_bcast && steer_live),
        .wr_idx(steer_idx),
        .wdata (bus_wdata),
        .copies(copies)
    );

    srb_semaphore u_sem (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_sem),
        .rel_hit(rel_sem),
        .grant  (sem_grant),
        .held   (sem_held)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                ADR_SEL:    bus_rdata <= DATA_W'(sel_word);
                ADR_SHARED: bus_rdata <= steer_live ? copies[steer_idx] : '0;
                ADR_SEM:    bus_rdata <= DATA_W'(sem_grant);
                default:    bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    a_r6_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_SHARED && (fuse_off[steer_idx] || pwr_gate[steer_idx]))
        |=> bus_rdata == '0);
    a_r7_absent_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_shared && !sel_bcast && !steer_live) |=> $stable(copies));
    a_r8_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sem && sem_held) |=> bus_rdata == '0);
    a_r2_sel_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_SEL) |=> bus_rdata[DATA_W-1:SEL_W] == '0);
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);
endmodule

// File: tb/steered_reg_bank_tb.sv
module steered_reg_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] fuse_off = '0;
    logic [15:0] pwr_gate = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] m_copy [16];
    logic [4:0]  m_sel;
    bit          m_held;

    steered_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fuse_off(fuse_off), .pwr_gate(pwr_gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int steer_of(logic [4:0] s);
        return int'(s[3:2]) * 4 + int'(s[1:0]);
    endfunction

    function automatic bit live(int idx);
        return !fuse_off[idx] && !pwr_gate[idx];
    endfunction

    function automatic logic [31:0] exp_shared();
        int idx = steer_of(m_sel);
        return live(idx) ? m_copy[idx] : 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_sel = d[4:0];
        else if (a == 2'd1) begin
            if (m_sel[4]) begin
                for (int i = 0; i < 16; i++) m_copy[i] = d;
            end else if (live(steer_of(m_sel))) m_copy[steer_of(m_sel)] = d;
        end else if (a == 2'd2 && d[0]) m_held = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_shared(string req);
        logic [31:0] v, e;
        e = exp_shared();
        rd(2'd1, v);
        check(req, v, e);
    endtask

    task automatic rd_sem(string req);
        logic [31:0] v, e;
        e = m_held ? 32'h0 : 32'h1;
        m_held = 1;
        rd(2'd2, v);
        check(req, v, e);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 16; i++) m_copy[i] = '0;
        m_sel = 5'h10; m_held = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 32'h0);
        rd(2'd0, v); check("R1 selector", v, 32'h10);
        rd_shared("R1 copy0");
        wr(2'd0, 32'h0000_000F);
        rd_shared("R1 copy15");
        // R2: upper bits dropped
        wr(2'd0, 32'hFFFF_FFF6);
        rd(2'd0, v); check("R2 readback", v, 32'h16);
        // R8 / R9 semaphore sequence
        rd_sem("R8 first take");
        rd_sem("R8 held");
        rd_sem("R8 held again");
        wr(2'd2, 32'h0000_0002);
        rd_sem("R9 zero write ignored");
        wr(2'd2, 32'h1);
        rd_sem("R9 release");
        wr(2'd2, 32'h1);
        // R3 broadcast then read all copies with both broadcast settings
        wr(2'd0, 32'h10);
        wr(2'd1, 32'hA5A5_0001);
        for (int i = 0; i < 16; i++) begin
            wr(2'd0, {27'd0, (i % 2 == 0), 4'(i)});
            rd_shared("R3 broadcast fill");
        end
        // R4 unicast touches one copy
        wr(2'd0, 32'h09);
        wr(2'd1, 32'h1234_5678);
        rd_shared("R4 target");
        wr(2'd0, 32'h08);
        rd_shared("R4 neighbour");
        wr(2'd0, 32'h19);
        rd_shared("R5 broadcast bit ignored on read");
        // R6 / R7 fuse and power gate
        wr(2'd0, 32'h05);
        @(negedge clk); fuse_off = 16'h0020;
        rd_shared("R6 fused read");
        wr(2'd1, 32'hDEAD_BEEF);
        @(negedge clk); fuse_off = 16'h0;
        rd_shared("R7 fused write dropped");
        @(negedge clk); pwr_gate = 16'h0020;
        rd_shared("R6 gated read");
        wr(2'd1, 32'h0BAD_F00D);
        @(negedge clk); pwr_gate = 16'h0;
        rd_shared("R7 gated write dropped");
        // R10 unmapped address
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v); check("R10 unmapped read", v, 32'h0);
        rd(2'd0, v); check("R10 selector unchanged", v, 32'h05);
        rd_shared("R10 copy unchanged");
        // random phase
        for (int n = 0; n < 600; n++) begin
            int op = int'($urandom % 8);
            if (op == 0) begin
                @(negedge clk);
                fuse_off = 16'($urandom) & 16'($urandom);
                pwr_gate = 16'($urandom) & 16'($urandom);
            end else if (op <= 2) wr(2'd0, $urandom);
            else if (op <= 4) wr(2'd1, $urandom);
            else if (op == 5) begin
                if ($urandom % 2 == 0) rd_sem("R8 random");
                else wr(2'd2, $urandom);
            end else rd_shared("R5 random read");
        end
        summary();
    end
endmodule